// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block sits between the serial pins of an SPI slave and the slave's transfer engine. It lets the bus master stop a transfer in the middle, without losing any bit, by pulling a pause pin low. The pins are brought into the system clock domain. The block tracks the level of the serial clock and decides when the pause starts and ends. It hands the engine only the clock edges that count, as one-cycle strobes.

While the pause is active, no strobes reach the engine. The engine's shift register and bit counter therefore keep their place, and the serial output enable is forced off. A pause starts or ends only while the serial clock is low. A change of the pause pin made while the clock is high waits for the next falling edge. If the master deselects the slave during a pause, the block sends the engine a one-cycle reset pulse, so that the half-finished transaction is dropped.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While selected (cs_n low), the pause becomes active when hold_n is low and the serial clock is low. `hold_active` rises within SYNC_STAGES+2 clock cycles.
- R2: A change of hold_n while the serial clock is high has no effect until the clock falls. A low pulse on hold_n that starts and ends within one clock-high phase never activates the pause.
- R3: While `hold_active` is 1, `sdo_oe` is 0 and no strobe appears on `sck_rise_o` or `sck_fall_o`.
- R4: `hold_active` is 0 whenever cs_n is high. A low hold_n while deselected never sets it.
- R5: The pause ends when hold_n is high and the serial clock is low. The falling clock edge that ends a deferred release is not forwarded. The first rising edge after the release is forwarded.
- R6: If cs_n goes high while the pause is active, `eng_rst` is high for exactly one cycle. `eng_rst` is never high otherwise.
- R7: While selected and not paused, each rising and falling serial clock edge gives exactly one one-cycle strobe of the matching kind, in order. The falling edge that starts a deferred pause is still forwarded. `sdo_oe` follows `eng_sdo_oe`. While deselected, no strobes appear and `sdo_oe` is 0.
- R8: During and after reset, with cs_n high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Active-low select pin |
| spi_hold_n | input | 1 | Active-low pause pin |
| eng_sdo_oe | input | 1 | Output enable requested by the engine |
| sck_rise_o | output | 1 | One-cycle strobe for a forwarded rising edge |
| sck_fall_o | output | 1 | One-cycle strobe for a forwarded falling edge |
| hold_active | output | 1 | Pause in effect |
| sdo_oe | output | 1 | Output enable to the data-out pad |
| eng_rst | output | 1 | One-cycle reset of the engine's transaction state |

## Verification
The hardest cases to reach are the deferred ones. Here hold_n moves while the serial clock is high, and the outcome depends on the next falling edge. That edge must be forwarded when it starts a pause and swallowed when it ends one. The stimulus parks the serial clock high, toggles hold_n, and only then drops the clock. A scoreboard of expected strobes proves that the right edge went missing and that the next rise resumes the sequence. A deselect during a pause is also driven, and the scoreboard expects exactly one reset pulse.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;
  typedef enum logic {
    PH_RUN    = 1'b0,
    PH_PAUSED = 1'b1
  } hold_phase_e;

  localparam int PIN_SCK   = 0;
  localparam int PIN_CS    = 1;
  localparam int PIN_HOLD  = 2;
  localparam int PIN_COUNT = 3;
endpackage

// File: rtl/hold_pin_sync.sv
`timescale 1ns/1ps
module hold_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_state_fsm.sv
`timescale 1ns/1ps
module hold_state_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic hold_s,
  output logic hold_active,
  output logic eng_rst
);
  hold_phase_e phase_q, phase_d;
  logic        rst_pulse_q, rst_pulse_d;

  // Pause entry and exit are level-qualified by a low serial clock.
  always_comb begin
    phase_d = phase_q;
    if (cs_s) begin
      phase_d = PH_RUN;
    end else if (phase_q == PH_RUN && !hold_s && !sck_s) begin
      phase_d = PH_PAUSED;
    end else if (phase_q == PH_PAUSED && hold_s && !sck_s) begin
      phase_d = PH_RUN;
    end
    rst_pulse_d = cs_s && (phase_q == PH_PAUSED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_RUN;
      rst_pulse_q <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      rst_pulse_q <= rst_pulse_d;
    end
  end

  assign hold_active = (phase_q == PH_PAUSED);
  assign eng_rst     = rst_pulse_q;

  a_r1_enter_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> ($past(!hold_s) && $past(!sck_s) && $past(!cs_s)));

  a_r5_exit_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active) && !$past(cs_s)) |-> ($past(hold_s) && $past(!sck_s)));

  a_r4_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !hold_active);

  a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !eng_rst);

  a_r6_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> ($past(hold_active) && $past(cs_s)));
endmodule

// File: rtl/hold_out_gate.sv
`timescale 1ns/1ps
module hold_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic hold_active,
  input  logic eng_sdo_oe,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdo_oe
);
  logic sck_prev_q;
  logic pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
    end
  end

  // Edges pass only while selected and not already paused.
  always_comb begin
    pass       = !cs_s && !hold_active;
    sck_rise_o = pass && sck_s && !sck_prev_q;
    sck_fall_o = pass && !sck_s && sck_prev_q;
    sdo_oe     = pass && eng_sdo_oe;
  end

  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_o |=> !sck_rise_o);

  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_o |=> !sck_fall_o);
endmodule

// File: rtl/spi_hold_ctrl.sv
`timescale 1ns/1ps
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_hold_n,
  input  logic eng_sdo_oe,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic hold_active,
  output logic sdo_oe,
  output logic eng_rst
);
  localparam logic [PIN_COUNT-1:0] PIN_RST = 3'b110;

  logic rst_meta_q, rst_int_n;
  logic [PIN_COUNT-1:0] pins_raw, pins_lvl;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign pins_raw = {spi_hold_n, spi_cs_n, spi_sck};

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    hold_pin_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST[p])
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .pin_i   (pins_raw[p]),
      .level_o (pins_lvl[p])
    );
  end

  hold_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sck_s       (pins_lvl[PIN_SCK]),
    .cs_s        (pins_lvl[PIN_CS]),
    .hold_s      (pins_lvl[PIN_HOLD]),
    .hold_active (hold_active),
    .eng_rst     (eng_rst)
  );

  hold_out_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sck_s       (pins_lvl[PIN_SCK]),
    .cs_s        (pins_lvl[PIN_CS]),
    .hold_active (hold_active),
    .eng_sdo_oe  (eng_sdo_oe),
    .sck_rise_o  (sck_rise_o),
    .sck_fall_o  (sck_fall_o),
    .sdo_oe      (sdo_oe)
  );

  a_r3_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(hold_active) && hold_active |-> !sck_rise_o && !sck_fall_o && !sdo_oe);
endmodule

// File: tb/spi_hold_ctrl_test.sv
`timescale 1ns/1ps
module spi_hold_ctrl_test;
  typedef enum logic [1:0] {EV_RISE, EV_FALL, EV_RST} ev_e;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, hold_n, eng_oe;
  logic rise_o, fall_o, hold_o, oe_o, rst_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  ev_e  exp_q[$];

  always #4 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .eng_sdo_oe(eng_oe), .sck_rise_o(rise_o),
    .sck_fall_o(fall_o), .hold_active(hold_o), .sdo_oe(oe_o), .eng_rst(rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Driver: one full serial clock pulse, pushing what should be forwarded.
  task automatic pulse(input bit fwd);
    if (fwd) exp_q.push_back(EV_RISE);
    sck = 1'b1;
    settle();
    if (fwd) exp_q.push_back(EV_FALL);
    sck = 1'b0;
    settle();
  endtask

  task automatic observe(input ev_e got);
    ev_e want;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R7/R3/R6 unexpected event", int'(got), -1);
    end else begin
      want = exp_q.pop_front();
      chk(got == want, "R7/R6 event order", int'(got), int'(want));
    end
  endtask

  // Monitor: pops expectations as strobes appear.
  initial begin
    forever begin
      @(negedge clk);
      if (rise_o) observe(EV_RISE);
      if (fall_o) observe(EV_FALL);
      if (rst_o)  observe(EV_RST);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; hold_n = 1'b1; eng_oe = 1'b1;
    repeat (5) @(negedge clk);
    chk(hold_o == 0 && oe_o == 0 && rst_o == 0, "R8 in reset", hold_o, 0);
    rst_n = 1'b1;
    settle();
    chk(hold_o == 0 && oe_o == 0 && rise_o == 0, "R8 after reset", oe_o, 0);

    // R7: normal transfer
    cs_n = 1'b0; settle();
    chk(oe_o == 1, "R7 oe follows engine", oe_o, 1);
    chk(hold_o == 0, "R7 not paused", hold_o, 0);
    repeat (3) pulse(1'b1);

    // R1 / R3: pause with clock low
    hold_n = 1'b0; settle();
    chk(hold_o == 1, "R1 enter clock low", hold_o, 1);
    chk(oe_o == 0, "R3 oe off in pause", oe_o, 0);
    repeat (2) pulse(1'b0);
    chk(hold_o == 1, "R3 clock ignored in pause", hold_o, 1);

    // R5: release with clock low, no strobe, then resume
    hold_n = 1'b1; settle();
    chk(hold_o == 0, "R5 exit clock low", hold_o, 0);
    chk(oe_o == 1, "R5 oe back", oe_o, 1);
    pulse(1'b1);

    // R2: entry deferred to falling edge, that fall forwarded
    exp_q.push_back(EV_RISE);
    sck = 1'b1; settle();
    hold_n = 1'b0; settle();
    chk(hold_o == 0, "R2 entry deferred while high", hold_o, 0);
    exp_q.push_back(EV_FALL);
    sck = 1'b0; settle();
    chk(hold_o == 1, "R2 entry at fall", hold_o, 1);

    // R2 / R5: release deferred, ending fall swallowed
    sck = 1'b1; settle();
    hold_n = 1'b1; settle();
    chk(hold_o == 1, "R2 exit deferred while high", hold_o, 1);
    sck = 1'b0; settle();
    chk(hold_o == 0, "R5 exit at fall", hold_o, 0);
    pulse(1'b1);

    // R2: short low pulse within clock-high phase
    exp_q.push_back(EV_RISE);
    sck = 1'b1; settle();
    hold_n = 1'b0; settle();
    hold_n = 1'b1; settle();
    exp_q.push_back(EV_FALL);
    sck = 1'b0; settle();
    chk(hold_o == 0, "R2 glitch ignored", hold_o, 0);

    // R4: deselected, hold low has no effect
    cs_n = 1'b1; hold_n = 1'b0; settle();
    chk(hold_o == 0, "R4 no pause deselected", hold_o, 0);
    chk(oe_o == 0, "R7 oe off deselected", oe_o, 0);
    pulse(1'b0);

    // R1 then R6: select into pause, deselect during pause
    cs_n = 1'b0; settle();
    chk(hold_o == 1, "R1 enter on select", hold_o, 1);
    exp_q.push_back(EV_RST);
    cs_n = 1'b1; settle();
    chk(hold_o == 0, "R4 deselect clears", hold_o, 0);
    chk(rst_o == 0, "R6 pulse ended", rst_o, 0);
    hold_n = 1'b1; cs_n = 1'b0; settle();
    pulse(1'b1);

    // R6: deselect outside pause gives no reset
    cs_n = 1'b1; settle();
    chk(rst_o == 0, "R6 no reset outside pause", rst_o, 0);

    settle();
    chk(exp_q.size() == 0, "R7 all expected events seen", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule